// File: doc/BRIEF.md
# Linear Page Table Translator

This block sits between a processor-side request port and a single physical memory port. Every virtual access passes through it: instruction fetches, loads and stores alike. It has no cache of translations. For each request it first reads one page-table entry from physical memory, and then, if that entry is marked present, it makes the real access at the translated physical address.

The virtual space is 64 KB with 1 KB pages. The top six address bits select a 16-bit entry in a flat table, and the entry address is the table base plus twice the page number. The base sits in a register that resets to physical address 1024. A side configuration port can rewrite the base, but only while the translator is idle.

An entry carries a present flag in its top bit and the frame number in its low bits. The frame number is joined to the untouched 10-bit page offset to form the physical address. If the entry is not present, the data access is skipped and the response is flagged as a fault for one cycle, together with the virtual address that faulted.

Top module: `pt_xlate`

## Requirements
- R1: After reset, req_ready is 1, mem_req is 0 and rsp_valid is 0, and the table base is 1024.
- R2: The first memory transaction of every request is a read (mem_we=0) at byte address base + 2*vaddr[15:10].
- R3: When the fetched entry has bit 15 set, the second transaction goes to address {entry[5:0], vaddr[9:0]}.
- R4: A read returns the data of the second transaction on rsp_rdata while rsp_valid is 1 with rsp_fault 0, and rsp_valid is high for exactly one cycle.
- R5: A store makes its second transaction with mem_we=1 and mem_wdata equal to the request's write data, unchanged by the entry read.
- R6: When the fetched entry has bit 15 clear, no second transaction is made, and rsp_valid and rsp_fault are both 1 for one cycle with rsp_vaddr equal to the request's virtual address.
- R7: Every request costs exactly two memory transactions (one if it faults), even when it repeats the previous virtual address.
- R8: req_ready stays 0 from the cycle after acceptance through the response cycle, so only one request is outstanding, and it returns to 1 the cycle after.
- R9: While mem_req is 1 and mem_ack is 0, mem_req, mem_addr and mem_we hold their values, for any latency.
- R10: A cfg_we pulse while idle sets the base for all following requests; a pulse while a request is in flight has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Translator can accept a request |
| req_write | input | 1 | 1 = store, 0 = fetch or load |
| req_vaddr | input | 16 | Virtual byte address |
| req_wdata | input | 16 | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Page not present (with rsp_valid) |
| rsp_rdata | output | 16 | Read data |
| rsp_vaddr | output | 16 | Virtual address of the response |
| cfg_we | input | 1 | Write the table base |
| cfg_base | input | 16 | New table base |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Physical byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |

## Verification
The bench goes after pages with the present bit clear. A design that ignored the bit would issue a stray data access, or would raise no fault, and the transaction count or the fault flag shows it. It repeats one virtual address back to back and stretches the memory latency. A design that reused a translation would show a single transaction, and one that let the address drift before the acknowledge would hit the wrong location. It writes the base both during a request and while idle. A design that accepted the write at any time would move the next entry read away from the expected address.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PTE  = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } xl_state_t;
endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int          PA_W    = 16,
  parameter logic [PA_W-1:0] RST_VAL = 16'd1024
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [PA_W-1:0] wr_data,
  output logic [PA_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst)        base <= RST_VAL;
    else if (wr_en) base <= wr_data;
  end
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int VPN_W = 6,
  parameter int PA_W  = 16,
  parameter int SHIFT = 1
) (
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  output logic [PA_W-1:0]  addr
);
  logic [PA_W-1:0] scaled;
  always_comb begin
    scaled = '0;
    scaled[VPN_W+SHIFT-1:SHIFT] = vpn;
    addr = base + scaled;
  end
endmodule

// File: rtl/pt_splice.sv
module pt_splice #(
  parameter int PFN_W = 6,
  parameter int OFF_W = 10
) (
  input  logic             present_bit,
  input  logic [PFN_W-1:0] pfn,
  input  logic [OFF_W-1:0] offset,
  output logic             present,
  output logic [PFN_W+OFF_W-1:0] paddr
);
  assign present = present_bit;
  assign paddr   = {pfn, offset};
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_xlate_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int OFF_W     = 10,
  parameter int PFN_W     = 6,
  parameter int PTE_W     = 16,
  parameter int DATA_W    = 16,
  parameter int PTE_BYTES = 2,
  parameter int BASE_RST  = 1024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic                     rsp_fault,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [VA_W-1:0]          rsp_vaddr,
  input  logic                     cfg_we,
  input  logic [PFN_W+OFF_W-1:0]   cfg_base,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [PFN_W+OFF_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic                     mem_ack,
  input  logic [DATA_W-1:0]        mem_rdata
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int SHIFT = $clog2(PTE_BYTES);
  localparam logic [PA_W-1:0] BASE_INIT = PA_W'(BASE_RST);

  xl_state_t        state;
  logic [VA_W-1:0]  va_q;
  logic             we_q;
  logic [DATA_W-1:0] wd_q;
  logic [PA_W-1:0]  base_q;
  logic [PA_W-1:0]  pte_addr;
  logic [PA_W-1:0]  data_addr;
  logic             pte_ok;
  logic             idle;

  assign idle      = (state == ST_IDLE);
  assign req_ready = idle;

  pt_base_reg #(.PA_W(PA_W), .RST_VAL(BASE_INIT)) u_base (
    .clk(clk), .rst(rst), .wr_en(cfg_we && idle), .wr_data(cfg_base), .base(base_q)
  );

  pt_entry_addr #(.VPN_W(VPN_W), .PA_W(PA_W), .SHIFT(SHIFT)) u_eaddr (
    .base(base_q), .vpn(req_vaddr[VA_W-1:OFF_W]), .addr(pte_addr)
  );

  pt_splice #(.PFN_W(PFN_W), .OFF_W(OFF_W)) u_splice (
    .present_bit(mem_rdata[PTE_W-1]), .pfn(mem_rdata[PFN_W-1:0]),
    .offset(va_q[OFF_W-1:0]), .present(pte_ok), .paddr(data_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      va_q      <= '0;
      we_q      <= 1'b0;
      wd_q      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
      rsp_vaddr <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            we_q     <= req_write;
            wd_q     <= req_wdata;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= pte_addr;
            state    <= ST_PTE;
          end
        end
        ST_PTE: begin
          if (mem_ack) begin
            if (pte_ok) begin
              mem_addr  <= data_addr;
              mem_we    <= we_q;
              mem_wdata <= wd_q;
              state     <= ST_DATA;
            end else begin
              mem_req   <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_rdata <= '0;
              rsp_vaddr <= va_q;
              state     <= ST_RESP;
            end
          end
        end
        ST_DATA: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_rdata <= we_q ? '0 : mem_rdata;
            rsp_vaddr <= va_q;
            state     <= ST_RESP;
          end
        end
        default: begin
          rsp_valid <= 1'b0;
          rsp_fault <= 1'b0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R2
  pte_read_first_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_req && !mem_we));

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R6
  fault_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> !mem_req);

  // R10
  base_busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!idle && cfg_we) |=> (base_q == $past(base_q)));
endmodule

// File: tb/pt_xlate_test.sv
module pt_xlate_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_vaddr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [15:0] rsp_rdata, rsp_vaddr;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_base = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  pt_xlate uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_vaddr(req_vaddr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
    .rsp_vaddr(rsp_vaddr), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0;

  // memory model with adjustable latency
  logic [15:0] mem_img [int];
  int          lat = 0, cnt = 0;
  logic        hold_err = 1'b0;
  logic [15:0] start_addr;
  logic [15:0] log_addr [8];
  logic        log_we   [8];
  logic [15:0] log_wd   [8];
  int          log_n = 0;

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem_img.exists(int'(a)) ? mem_img[int'(a)] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; mem_rdata <= '0; cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; cnt <= 0;
    end else if (mem_req) begin
      if (cnt == 0) start_addr = mem_addr;
      else if (mem_addr != start_addr) hold_err = 1'b1;
      if (cnt >= lat) begin
        mem_ack <= 1'b1;
        mem_rdata <= rd(mem_addr);
        if (mem_we) mem_img[int'(mem_addr)] = mem_wdata;
        if (log_n < 8) begin
          log_addr[log_n] = mem_addr; log_we[log_n] = mem_we; log_wd[log_n] = mem_wdata;
        end
        log_n++;
        cnt <= 0;
      end else cnt <= cnt + 1;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ent(input logic [15:0] base, input logic [15:0] va);
    return base + {9'd0, va[15:10], 1'b0};
  endfunction

  logic        g_fault, g_ready_in_rsp, g_valid_after, g_ready_after, g_busy_ready;
  logic [15:0] g_rdata, g_va;

  // drives one request; optional base write while busy
  task automatic run_req(input logic w, input logic [15:0] va, input logic [15:0] wd,
                         input logic busy_cfg, input logic [15:0] busy_base);
    int n;
    log_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_vaddr = va; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (busy_cfg) begin cfg_we = 1'b1; cfg_base = busy_base; end
    n = 0; g_busy_ready = 1'b0;
    while (!rsp_valid && n < 400) begin
      if (req_ready) g_busy_ready = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      n++;
    end
    cfg_we = 1'b0;
    if (n >= 400) chk("R8 response timeout", 32'(n), 32'(0));
    g_fault = rsp_fault; g_rdata = rsp_rdata; g_va = rsp_vaddr;
    g_ready_in_rsp = req_ready;
    @(negedge clk);
    g_valid_after = rsp_valid; g_ready_after = req_ready;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'(1));
    chk("R1 no mem req after reset", 32'(mem_req), 32'(0));
    chk("R1 no response after reset", 32'(rsp_valid), 32'(0));
  endtask

  task automatic t_read(input logic [15:0] base, input logic [15:0] va, input logic [5:0] pfn,
                        input int l);
    logic [15:0] pa;
    lat = l;
    pa = {pfn, va[9:0]};
    mem_img[int'(pa)] = va ^ 16'h5A5A;
    run_req(1'b0, va, 16'h0, 1'b0, 16'h0);
    chk("R7 two transactions", 32'(log_n), 32'(2));
    chk("R2 entry address", 32'(log_addr[0]), 32'(ent(base, va)));
    chk("R2 entry read", 32'(log_we[0]), 32'(0));
    chk("R3 physical address", 32'(log_addr[1]), 32'(pa));
    chk("R4 read data", 32'(g_rdata), 32'(va ^ 16'h5A5A));
    chk("R4 no fault", 32'(g_fault), 32'(0));
    chk("R4 one-cycle response", 32'(g_valid_after), 32'(0));
    chk("R8 ready low while busy", 32'(g_busy_ready | g_ready_in_rsp), 32'(0));
    chk("R8 ready returns", 32'(g_ready_after), 32'(1));
  endtask

  task automatic t_write;
    lat = 2;
    run_req(1'b1, 16'h9C50, 16'hBEEF, 1'b0, 16'h0);
    chk("R5 two transactions", 32'(log_n), 32'(2));
    chk("R5 data write enable", 32'(log_we[1]), 32'(1));
    chk("R5 write data unchanged", 32'(log_wd[1]), 32'(16'hBEEF));
    chk("R5 address", 32'(log_addr[1]), 32'({6'd7, 10'h050}));
    chk("R5 memory updated", 32'(rd({6'd7, 10'h050})), 32'(16'hBEEF));
    run_req(1'b0, 16'h9C50, 16'h0, 1'b0, 16'h0);
    chk("R5 read back", 32'(g_rdata), 32'(16'hBEEF));
  endtask

  task automatic t_fault;
    lat = 1;
    run_req(1'b0, 16'h1733, 16'h0, 1'b0, 16'h0);
    chk("R6 only entry read", 32'(log_n), 32'(1));
    chk("R6 fault flag", 32'(g_fault), 32'(1));
    chk("R6 fault vaddr", 32'(g_va), 32'(16'h1733));
    chk("R6 one-cycle fault", 32'(g_valid_after), 32'(0));
    run_req(1'b1, 16'h1400, 16'h1234, 1'b0, 16'h0);
    chk("R6 store fault no write", 32'(log_n), 32'(1));
    chk("R6 store fault flag", 32'(g_fault), 32'(1));
  endtask

  task automatic t_repeat;
    lat = 0;
    for (int k = 0; k < 3; k++) begin
      run_req(1'b0, 16'h0424, 16'h0, 1'b0, 16'h0);
      chk("R7 repeat costs two", 32'(log_n), 32'(2));
    end
  endtask

  task automatic t_latency;
    hold_err = 1'b0;
    t_read(16'd1024, 16'hA3FE, 6'd8, 7);
    chk("R9 address held until ack", 32'(hold_err), 32'(0));
  endtask

  task automatic t_cfg;
    lat = 3;
    mem_img[int'(ent(16'h2000, 16'h0424))] = 16'h8009;
    run_req(1'b0, 16'h0424, 16'h0, 1'b1, 16'h2000);
    chk("R10 busy write ignored now", 32'(log_addr[0]), 32'(ent(16'd1024, 16'h0424)));
    run_req(1'b0, 16'h0424, 16'h0, 1'b0, 16'h0);
    chk("R10 busy write ignored later", 32'(log_addr[0]), 32'(ent(16'd1024, 16'h0424)));
    @(negedge clk); cfg_we = 1'b1; cfg_base = 16'h2000;
    @(negedge clk); cfg_we = 1'b0;
    t_read(16'h2000, 16'h0424, 6'd9, 1);
    @(negedge clk); cfg_we = 1'b1; cfg_base = 16'd1024;
    @(negedge clk); cfg_we = 1'b0;
    run_req(1'b0, 16'h0424, 16'h0, 1'b0, 16'h0);
    chk("R10 base restored", 32'(log_addr[0]), 32'(ent(16'd1024, 16'h0424)));
  endtask

  initial begin
    // table at 1024: page1->4, page39->7, page40->8, page41->9, page5 absent
    mem_img[int'(ent(16'd1024, 16'h0400))] = 16'h8004;
    mem_img[int'(ent(16'd1024, 16'h9C00))] = 16'h8007;
    mem_img[int'(ent(16'd1024, 16'hA000))] = 16'h8008;
    mem_img[int'(ent(16'd1024, 16'hA400))] = 16'h8009;
    mem_img[int'(ent(16'd1024, 16'h1400))] = 16'h0004;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_read(16'd1024, 16'h0424, 6'd4, 0);
    t_read(16'd1024, 16'hA7FF, 6'd9, 4);
    t_write;
    t_fault;
    t_repeat;
    t_latency;
    t_cfg;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule